// File: doc/BRIEF.md
# Cache Block Refill Engine

After a cache miss, this block brings one 16-word block in from main memory and writes it into the cache line. The memory organisation is fixed at build time by a parameter, and there are three choices. The first is a memory one word wide. The second is a memory four words wide with a four-word bus. The third is four banks that are accessed together and then drained one word at a time over a single-word bus.

For each organisation the engine spends one cycle sending the address. Every access then costs a fixed latency, and every bus transfer costs one cycle. The miss penalty of each organisation therefore comes out exactly: 177 cycles for the narrow memory, 45 for the wide one and 57 for the interleaved one. The cache sees a write strobe, the index of the first word carried, and the data. A running cycle counter shows how far the fill has gone and then holds the penalty.

Main memory is modelled inside the block. Its contents are a fixed function of the word address, so a test can predict every word.

Top module: `refill_engine`

## Requirements
- R1: After reset, `busy`, `fill_we` and `done` are low and `cycle_count` is 0.
- R2: A `start` pulse seen while idle is accepted at that clock edge. In the first cycle after it, `busy` is high and `cycle_count` is 1, and `cycle_count` then rises by one every cycle until the fill ends.
- R3: `start` seen while `busy` is high has no effect on the address, the transfer timing or the count.
- R4: With ORG=0 (narrow), one word is written in each cycle where `cycle_count` equals 12+11g, for g = 0..15, with `fill_idx` = g. The penalty is 177.
- R5: With ORG=1 (wide), `fill_data` is 128 bits, and lane j (bits 32j+31:32j) carries word `fill_idx`+j. Writes occur where `cycle_count` equals 12+11g, for g = 0..3, with `fill_idx` = 4g. The penalty is 45.
- R6: With ORG=2 (interleaved), one word is written in each cycle where `cycle_count` equals 42+i, for i = 0..15, with `fill_idx` = i. The penalty is 57.
- R7: Words arrive in ascending index order. Word i of a fill equals M(B+i). Here B is `start_addr` with its low 4 bits cleared, and M(a) = (a × 0x9E3779B1) XOR 0xA5A50F0F, taken modulo 2^32.
- R8: `done` is high for exactly one cycle, the cycle in which `cycle_count` equals the penalty. In the next cycle `busy` is low, and `cycle_count` holds the penalty until the next start.
- R9: `fill_we` is low in every cycle that is not a transfer cycle, including all idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fill (ignored while busy) |
| start_addr | input | ADDR_W | Word address of the missing block |
| busy | output | 1 | Fill in progress |
| fill_we | output | 1 | Cache write strobe |
| fill_idx | output | 4 | Index in the block of the first word on `fill_data` |
| fill_data | output | LANES*DATA_W | Words to the cache (32 bits, or 128 bits when ORG=1) |
| done | output | 1 | Last transfer of the fill |
| cycle_count | output | CNT_W | Cycles since the fill began; holds the penalty afterwards |

## Verification
The bench builds three copies side by side, one for each of ORG=0, 1 and 2, with all other parameters at their defaults. Each fill is started on all three copies at once. This puts the three penalties, 177, 45 and 57, and every transfer slot on the same time axis. It also makes a start request in the middle of a fill meet all three copies while they are busy. The block addresses are random, plus addresses whose low bits are set, so the clearing of the low bits and the data of every lane are both checked.

// File: rtl/refill_engine.sv
module refill_engine #(
  parameter int ORG    = 0,
  parameter int WORDS  = 16,
  parameter int BUS    = 4,
  parameter int LAT    = 10,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int LANES = (ORG == 1) ? BUS : 1,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         start_addr,
  output logic                      busy,
  output logic                      fill_we,
  output logic [IDX_W-1:0]          fill_idx,
  output logic [LANES*DATA_W-1:0]   fill_data,
  output logic                      done,
  output logic [CNT_W-1:0]          cycle_count
);
  localparam int GAP0   = 1 + ((ORG == 2) ? BUS * LAT : LAT);
  localparam int GAPN   = (ORG == 2) ? 0 : LAT;
  localparam int WAIT_W = $clog2(GAP0 + 1);

  logic                    busy_q;
  logic [WAIT_W-1:0]       wait_q;
  logic [IDX_W-1:0]        idx_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [ADDR_W-IDX_W-1:0] base_q;
  logic                    xfer, last;

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    logic [31:0] h;
    h = (32'(a) * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
    return DATA_W'(h);
  endfunction

  assign xfer = busy_q && (wait_q == '0);
  assign last = xfer && (idx_q == IDX_W'(WORDS - LANES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        wait_q <= WAIT_W'(GAP0);
        idx_q  <= '0;
        cnt_q  <= CNT_W'(1);
        base_q <= start_addr[ADDR_W-1:IDX_W];
      end
    end else begin
      if (!last) cnt_q <= cnt_q + 1'b1;
      if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        idx_q  <= idx_q + IDX_W'(LANES);
        wait_q <= WAIT_W'(GAPN);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign fill_data[j*DATA_W +: DATA_W] = mem_word({base_q, idx_q + IDX_W'(j)});
  end

  assign busy        = busy_q;
  assign fill_we     = xfer;
  assign fill_idx    = idx_q;
  assign done        = last;
  assign cycle_count = cnt_q;
endmodule

// File: rtl/refill_engine_chk.sv
module refill_engine_chk #(
  parameter int ORG   = 0,
  parameter int WORDS = 16,
  parameter int BUS   = 4,
  parameter int LAT   = 10,
  parameter int CNT_W = 8,
  parameter int IDX_W = 4,
  parameter int LANES = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             fill_we,
  input logic [IDX_W-1:0] fill_idx,
  input logic             done,
  input logic [CNT_W-1:0] cycle_count
);
  localparam int PEN = (ORG == 2) ? (1 + BUS * LAT + WORDS) : (1 + (WORDS / LANES) * (LAT + 1));

  assert_done_at_penalty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycle_count == CNT_W'(PEN)));

  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_done_last_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fill_we && fill_idx == IDX_W'(WORDS - LANES)));

  assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy && cycle_count == $past(cycle_count) + 1'b1));

  assert_first_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cycle_count == CNT_W'(1)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fill_we && !done));
endmodule

bind refill_engine refill_engine_chk #(
  .ORG(ORG), .WORDS(WORDS), .BUS(BUS), .LAT(LAT), .CNT_W(CNT_W),
  .IDX_W(IDX_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .fill_we(fill_we),
  .fill_idx(fill_idx), .done(done), .cycle_count(cycle_count)
);

// File: tb/refill_engine_tb.sv
`timescale 1ns/1ps
module refill_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] start_addr = '0;
  int checks = 0;
  int errors = 0;

  logic busy0, we0, done0, busy1, we1, done1, busy2, we2, done2;
  logic [3:0] idx0, idx1, idx2;
  logic [31:0] d0, d2;
  logic [127:0] d1;
  logic [7:0] c0, c1, c2;

  always #2.5 clk = ~clk;

  refill_engine #(.ORG(0)) u_dut (.clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy0), .fill_we(we0), .fill_idx(idx0), .fill_data(d0), .done(done0), .cycle_count(c0));
  refill_engine #(.ORG(1)) u_dut_wide (.clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy1), .fill_we(we1), .fill_idx(idx1), .fill_data(d1), .done(done1), .cycle_count(c1));
  refill_engine #(.ORG(2)) u_dut_intl (.clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy2), .fill_we(we2), .fill_idx(idx2), .fill_data(d2), .done(done2), .cycle_count(c2));

  function automatic logic [31:0] mword(input logic [7:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

  function automatic int pen(input int org);
    return (org == 0) ? 177 : (org == 1) ? 45 : 57;
  endfunction

  function automatic int exp_idx(input int org, input int k);
    if (org == 2) return (k >= 42 && k <= 57) ? k - 42 : -1;
    if (k >= 12 && (k - 12) % 11 == 0) begin
      if (org == 0 && (k - 12) / 11 < 16) return (k - 12) / 11;
      if (org == 1 && (k - 12) / 11 < 4) return 4 * ((k - 12) / 11);
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_one(input int org, input int k, input logic [7:0] base,
                           input logic b, input logic we, input logic [3:0] idx,
                           input logic [127:0] dat, input logic dn, input logic [7:0] cc);
    int p = pen(org);
    int e;
    string rq;
    logic [127:0] ed;
    rq = (org == 0) ? "R4" : (org == 1) ? "R5" : "R6";
    if (k <= p) begin
      e = exp_idx(org, k);
      chk(b == 1'b1, "R2 busy", 128'(b), 128'd1);
      chk(cc == 8'(k), "R2 count", 128'(cc), 128'(k));
      chk(we == (e >= 0), (e >= 0) ? rq : "R9", 128'(we), 128'(e >= 0));
      if (e >= 0 && we) begin
        chk(idx == 4'(e), "R7 index", 128'(idx), 128'(e));
        ed = '0;
        for (int j = 0; j < ((org == 1) ? 4 : 1); j++)
          ed[j*32 +: 32] = mword(base + 8'(e + j));
        chk(dat == ed, "R7 data", dat, ed);
      end
      chk(dn == (k == p), "R8 done", 128'(dn), 128'(k == p));
    end else if (k == p + 1) begin
      chk(b == 1'b0 && dn == 1'b0 && we == 1'b0, "R8 idle", 128'({b, dn, we}), 128'd0);
      chk(cc == 8'(p), rq, 128'(cc), 128'(p));
    end
  endtask

  task automatic run_fill(input logic [7:0] a, input bit poke);
    logic [7:0] base = {a[7:4], 4'b0};
    @(negedge clk);
    start = 1'b1;
    start_addr = a;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 179; k++) begin
      check_one(0, k, base, busy0, we0, idx0, 128'(d0), done0, c0);
      check_one(1, k, base, busy1, we1, idx1, d1, done1, c1);
      check_one(2, k, base, busy2, we2, idx2, 128'(d2), done2, c2);
      if (poke && (k == 30 || k == 31)) begin
        start = 1'b1;
        start_addr = ~a;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({busy0, we0, done0, busy1, we1, done1, busy2, we2, done2} == '0, "R1 flags",
        128'({busy0, we0, done0, busy1, we1, done1, busy2, we2, done2}), 128'd0);
    chk(c0 == 0 && c1 == 0 && c2 == 0, "R1 count", 128'({c0, c1, c2}), 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!we0 && !we1 && !we2 && !busy0, "R9 idle", 128'({we0, we1, we2, busy0}), 128'd0);
    run_fill(8'h00, 1'b0);
    run_fill(8'hFF, 1'b0);
    run_fill(8'h37, 1'b1);
    for (int n = 0; n < 16; n++) run_fill(8'($urandom), n[1]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule